// File: doc/BRIEF.md
# Event-Triggered Transfer Count Sequencer

This block keeps the transfer counts for a small event-triggered data mover. Up to 56 request sources raise activation requests. Each source has its own enable bit, and only enabled sources are considered. The block grants the lowest-numbered pending source. It holds that grant until the mover reports one transferred unit on the `unit_done` strobe.

Every accepted strobe advances the counters according to the selected mode:

- **Normal mode** uses count register A as one 16-bit down-counter.
- **Repeat mode** splits count register A into a reload byte (upper) and a working byte (lower). The working byte reloads from the reload byte every time it runs out.
- **Block mode** uses the same split. In addition, count register B counts the blocks still to go.

When a normal or block run finishes, the block pulses `xfer_done`. In the same edge it clears the enable bit of the source being served. Software loads the counters and the enable bytes through a simple write port and reads them back through a combinational read port.

Top module: `xfer_count_seq`

## Requirements
- R1: In normal mode (`mode`=0), each accepted strobe decrements the 16-bit count A by one, with a loaded value N finishing on the Nth strobe. A loaded 0 means 65536, so the first strobe leaves A at 16'hFFFF without finishing.
- R2: On the edge that ends a normal or block run, `xfer_done` pulses high for one cycle. In that same edge the enable bit of the granted source is cleared.
- R3: In repeat (`mode`=1) and block (`mode`=2) modes, each strobe decrements the lower byte of count A. When that byte would reach zero, it is reloaded from the upper byte instead and `block_end` pulses for one cycle. A lower byte of 0 means 256 strobes.
- R4: Repeat mode never asserts `xfer_done`, however many blocks complete.
- R5: In block mode, count B (address 1) decrements once per completed block. The run finishes on the block that takes B from 1 to 0, and a loaded B of 0 means 65536 blocks.
- R6: The enables are seven 8-bit registers at addresses 2 to 8. Bit j at address 2+k enables source 8k+j. They reset to zero and read back what was written, zero-extended on `rd_data`. Address 0 reads count A.
- R7: A request from a source whose enable bit is clear is ignored. Among the pending enabled requests, the lowest index is granted one cycle after it is seen.
- R8: A grant stays on the same index until a strobe is accepted, even if the request drops. The grant is released at that edge, and the next grant can appear one cycle later.
- R9: A write to count A or count B in the same cycle as an accepted strobe wins. The written value is loaded, and that strobe causes no count step and no pulse.
- R10: Normal mode never pulses `block_end`. Mode value 3 performs no counting and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0 count A, 1 count B, 2..8 enable bytes) |
| wr_data | input | 16 | Write data (enable bytes use bits 7:0) |
| rd_addr | input | 4 | Read address, same map |
| rd_data | output | 16 | Combinational readback |
| mode | input | 2 | 0 normal, 1 repeat, 2 block, 3 idle |
| req | input | 56 | Per-source activation requests |
| unit_done | input | 1 | One unit transferred for the current grant |
| grant_valid | output | 1 | A source is granted |
| grant_idx | output | 6 | Index of the granted source |
| block_end | output | 1 | One-cycle pulse at each block boundary |
| xfer_done | output | 1 | One-cycle pulse when a normal or block run ends |

## Verification
The bench goes after the zero-means-maximum encodings:

- A lower byte of zero must take 256 strobes before the first block boundary. A design that treated zero as empty would signal at once or never.
- A normal-mode count of zero must wrap to 16'hFFFF instead of finishing.

It also checks that the source of a finished run loses its enable bit. A design that missed this would keep regranting that source.

Repeat mode is driven across several reloads to confirm that it never finishes. A grant is held while its request drops, to catch an arbiter that re-picks every cycle.

A count write is issued in the same cycle as a strobe. A design that let the decrement win would show the written value minus one, or a spurious completion pulse.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int EN_BYTES = 7;
    localparam int N_SRC    = EN_BYTES * BYTE_W;
    localparam int IDX_W    = $clog2(N_SRC);
    localparam int ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] ADDR_CNT_A = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT_B = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_EN0   = 4'd2;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_BLOCK  = 2'd2,
        MODE_IDLE   = 2'd3
    } xfc_mode_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } xfc_grant_t;

    typedef struct packed {
        logic block_end;
        logic done;
    } xfc_event_t;

    // Address of enable byte k
    function automatic logic [ADDR_W-1:0] en_addr(input int k);
        return ADDR_EN0 + ADDR_W'(k);
    endfunction

    // Count of one is the last step; zero encodes the maximum
    function automatic logic is_last(input logic [CNT_W-1:0] v);
        return v == CNT_W'(1);
    endfunction

endpackage

// File: rtl/xfc_enable_bank.sv
module xfc_enable_bank
    import xfc_pkg::*;
#(
    parameter int NBYTES = EN_BYTES,
    parameter int BW     = BYTE_W,
    localparam int NBITS = NBYTES * BW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BW-1:0]     wr_byte,
    input  logic [NBITS-1:0]  clr_vec,
    output logic [NBITS-1:0]  en_bits
);

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        logic          hit;
        logic [BW-1:0] nxt;

        assign hit = wr_en && (wr_addr == en_addr(k));

        always_comb begin
            nxt = en_bits[k*BW +: BW];
            if (hit) begin
                nxt = wr_byte;
            end
            // automatic clear wins over a same-cycle write
            nxt = nxt & ~clr_vec[k*BW +: BW];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_bits[k*BW +: BW] <= '0;
            end else begin
                en_bits[k*BW +: BW] <= nxt;
            end
        end
    end

endmodule

// File: rtl/xfc_src_arbiter.sv
module xfc_src_arbiter
    import xfc_pkg::*;
#(
    parameter int NS = N_SRC,
    localparam int IW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] req,
    input  logic [NS-1:0] en_bits,
    input  logic          unit_done,
    output logic          grant_valid,
    output logic [IW-1:0] grant_idx
);

    logic [NS-1:0] pend;
    logic          any_pend;
    logic [IW-1:0] pick;
    logic          release_now;

    assign pend = req & en_bits;

    // lowest index wins: scan from the top so the lowest overwrites last
    always_comb begin
        any_pend = 1'b0;
        pick     = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any_pend = 1'b1;
                pick     = IW'(i);
            end
        end
    end

    assign release_now = grant_valid && unit_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
        end else if (release_now) begin
            grant_valid <= 1'b0;
        end else if (!grant_valid && any_pend) begin
            grant_valid <= 1'b1;
            grant_idx   <= pick;
        end
    end

endmodule

// File: rtl/xfc_count_unit.sv
module xfc_count_unit
    import xfc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int BW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  xfc_mode_e         mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic [CW-1:0]     cnt_a,
    output logic [CW-1:0]     cnt_b,
    output logic              finish_now,
    output xfc_event_t        evt
);

    logic          wr_a;
    logic          wr_b;
    logic          step_eff;
    logic [BW-1:0] lo;
    logic [BW-1:0] hi;
    logic          lo_last;
    logic [CW-1:0] a_nxt;
    logic [CW-1:0] b_nxt;
    xfc_event_t    evt_nxt;

    assign wr_a     = wr_en && (wr_addr == ADDR_CNT_A);
    assign wr_b     = wr_en && (wr_addr == ADDR_CNT_B);
    assign step_eff = step && !wr_a && !wr_b;
    assign lo       = cnt_a[BW-1:0];
    assign hi       = cnt_a[CW-1:BW];
    assign lo_last  = (lo == BW'(1));

    always_comb begin
        a_nxt   = cnt_a;
        b_nxt   = cnt_b;
        evt_nxt = '0;
        if (step_eff) begin
            unique case (mode)
                MODE_NORMAL: begin
                    a_nxt        = cnt_a - CW'(1);
                    evt_nxt.done = is_last(cnt_a);
                end
                MODE_REPEAT: begin
                    if (lo_last) begin
                        a_nxt             = {hi, hi};
                        evt_nxt.block_end = 1'b1;
                    end else begin
                        a_nxt = {hi, lo - BW'(1)};
                    end
                end
                MODE_BLOCK: begin
                    if (lo_last) begin
                        a_nxt             = {hi, hi};
                        b_nxt             = cnt_b - CW'(1);
                        evt_nxt.block_end = 1'b1;
                        evt_nxt.done      = is_last(cnt_b);
                    end else begin
                        a_nxt = {hi, lo - BW'(1)};
                    end
                end
                default: begin
                end
            endcase
        end
        if (wr_a) begin
            a_nxt = wr_data;
        end
        if (wr_b) begin
            b_nxt = wr_data;
        end
    end

    assign finish_now = evt_nxt.done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_a <= '0;
            cnt_b <= '0;
            evt   <= '0;
        end else begin
            cnt_a <= a_nxt;
            cnt_b <= b_nxt;
            evt   <= evt_nxt;
        end
    end

endmodule

// File: rtl/xfer_count_seq.sv
module xfer_count_seq
    import xfc_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [1:0]        mode,
    input  logic [N_SRC-1:0]  req,
    input  logic              unit_done,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              block_end,
    output logic              xfer_done
);

    logic [N_SRC-1:0] en_bits;
    logic [N_SRC-1:0] clr_vec;
    logic [CNT_W-1:0] cnt_a;
    logic [CNT_W-1:0] cnt_b;
    logic             finish_now;
    logic             step;
    xfc_event_t       evt;
    xfc_grant_t       gnt;

    assign step = grant_valid && unit_done;

    xfc_src_arbiter #(.NS(N_SRC)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .en_bits    (en_bits),
        .unit_done  (unit_done),
        .grant_valid(gnt.valid),
        .grant_idx  (gnt.idx)
    );

    assign grant_valid = gnt.valid;
    assign grant_idx   = gnt.idx;

    xfc_count_unit u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .mode      (xfc_mode_e'(mode)),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_a     (cnt_a),
        .cnt_b     (cnt_b),
        .finish_now(finish_now),
        .evt       (evt)
    );

    always_comb begin
        clr_vec = '0;
        if (finish_now) begin
            clr_vec[gnt.idx] = 1'b1;
        end
    end

    xfc_enable_bank u_en (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_byte(wr_data[BYTE_W-1:0]),
        .clr_vec(clr_vec),
        .en_bits(en_bits)
    );

    assign block_end = evt.block_end;
    assign xfer_done = evt.done;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CNT_A) begin
            rd_data = cnt_a;
        end else if (rd_addr == ADDR_CNT_B) begin
            rd_data = cnt_b;
        end else begin
            for (int k = 0; k < EN_BYTES; k++) begin
                if (rd_addr == en_addr(k)) begin
                    rd_data = {{(CNT_W-BYTE_W){1'b0}}, en_bits[k*BYTE_W +: BYTE_W]};
                end
            end
        end
    end

endmodule

// File: rtl/xfer_count_seq_chk.sv
module xfer_count_seq_chk
    import xfc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [1:0]        mode,
    input logic [N_SRC-1:0]  req,
    input logic              unit_done,
    input logic              grant_valid,
    input logic [IDX_W-1:0]  grant_idx,
    input logic              block_end,
    input logic              xfer_done,
    input logic [N_SRC-1:0]  en_bits,
    input logic [CNT_W-1:0]  cnt_a
);

    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] below_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= req & en_bits;
        end
    end

    assign below_mask = ({{(N_SRC-1){1'b0}}, 1'b1} << grant_idx) - N_SRC'(1);

    // R7: a new grant was pending and enabled in the previous cycle
    p_grant_pending_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> pend_q[grant_idx]);

    // R7: no lower-indexed source was pending when the grant was taken
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> ((pend_q & below_mask) == '0));

    // R8: grant holds until a strobe is accepted
    p_grant_held_r8: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !unit_done) |=> (grant_valid && $stable(grant_idx)));

    // R8: strobe releases the grant
    p_grant_release_r8: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && unit_done) |=> !grant_valid);

    // R4: repeat mode never completes
    p_repeat_no_done_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |=> !xfer_done);

    // R10: normal mode has no block boundaries
    p_normal_no_blk_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |=> !block_end);

    // R2: finished source loses its enable bit
    p_done_clears_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !en_bits[$past(grant_idx)]);

    // R9: a count A write always lands
    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CNT_A) |=> (cnt_a == $past(wr_data)));

endmodule

bind xfer_count_seq xfer_count_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mode       (mode),
    .req        (req),
    .unit_done  (unit_done),
    .grant_valid(grant_valid),
    .grant_idx  (grant_idx),
    .block_end  (block_end),
    .xfer_done  (xfer_done),
    .en_bits    (en_bits),
    .cnt_a      (cnt_a)
);

// File: tb/xfer_count_seq_bench.sv
`timescale 1ns/1ps
module xfer_count_seq_bench;
    import xfc_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CNT_W-1:0]  wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  rd_data;
    logic [1:0]        mode;
    logic [N_SRC-1:0]  req;
    logic              unit_done;
    logic              grant_valid;
    logic [IDX_W-1:0]  grant_idx;
    logic              block_end;
    logic              xfer_done;

    int n_checks = 0;
    int n_errors = 0;
    bit got_blk;
    bit got_done;

    always #2.5 clk = ~clk;

    xfer_count_seq u_xfer_count_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode), .req(req),
        .unit_done(unit_done), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .block_end(block_end), .xfer_done(xfer_done)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        mode = 2'd0; req = '0; unit_done = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [CNT_W-1:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // waits for a grant, strobes one unit, reports pulses seen after the edge
    task automatic unit(output bit blk, output bit dn);
        int guard = 0;
        while (!grant_valid && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        unit_done = 1;
        @(negedge clk);
        unit_done = 0;
        blk = block_end;
        dn  = xfer_done;
    endtask

    task automatic t_reset();
        logic [CNT_W-1:0] d;
        do_reset();
        for (int k = 0; k < EN_BYTES; k++) begin
            rd(ADDR_EN0 + ADDR_W'(k), d);
            check("R6 enable reset zero", d, 0);
        end
        check("R6 no grant after reset", grant_valid, 0);
    endtask

    task automatic t_enable_map();
        logic [CNT_W-1:0] d;
        do_reset();
        wr(4'd2, 16'h00A5);
        wr(4'd8, 16'hFF3C);
        rd(4'd2, d); check("R6 enable byte0 readback", d, 16'h00A5);
        rd(4'd8, d); check("R6 enable byte6 readback", d, 16'h003C);
        // source 8*6+2 = 50 enabled via byte6 bit2
        req = '0; req[50] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R6 byte6 bit2 is source 50", {grant_valid, grant_idx}, {1'b1, 6'd50});
    endtask

    task automatic t_ignore_disabled();
        do_reset();
        req = '0; req[5] = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 disabled request ignored", grant_valid, 0);
    endtask

    task automatic t_priority_hold();
        do_reset();
        wr(4'd2, 16'h0008);           // source 3
        wr(4'd3, 16'h0004);           // source 10
        req = '0; req[10] = 1'b1;
        @(negedge clk);
        req[3] = 1'b1;                // same cycle as grant of 10? grant taken at edge just passed
        @(negedge clk);
        check("R8 first grant kept", grant_idx, 10);
        req[10] = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 grant held after request drop", {grant_valid, grant_idx}, {1'b1, 6'd10});
        mode = 2'd3;
        unit_done = 1;
        @(negedge clk);
        unit_done = 0;
        check("R8 released at strobe", grant_valid, 0);
        @(negedge clk);
        check("R7 lowest pending granted next", {grant_valid, grant_idx}, {1'b1, 6'd3});
    endtask

    task automatic t_priority_lowest();
        do_reset();
        wr(4'd2, 16'h0008);
        wr(4'd3, 16'h0004);
        req = '0; req[10] = 1'b1; req[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R7 lowest of two granted", grant_idx, 3);
    endtask

    task automatic t_normal();
        logic [CNT_W-1:0] d;
        int dones = 0;
        do_reset();
        mode = 2'd0;
        wr(4'd0, 16'd3);
        wr(4'd2, 16'h0010);           // source 4
        req = '0; req[4] = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            unit(got_blk, got_done);
            if (got_blk) check("R10 no block_end in normal", 1, 0);
            if (got_done) dones++;
            if (i == 3) check("R1 done on third unit", got_done, 1);
        end
        check("R2 exactly one done", dones, 1);
        rd(4'd0, d); check("R1 count A reaches zero", d, 0);
        rd(4'd2, d); check("R2 enable of served source cleared", d, 0);
        @(negedge clk); @(negedge clk);
        check("R2 no regrant after done", grant_valid, 0);
    endtask

    task automatic t_normal_zero();
        logic [CNT_W-1:0] d;
        do_reset();
        mode = 2'd0;
        wr(4'd2, 16'h0001);
        req = '0; req[0] = 1'b1;
        unit(got_blk, got_done);
        check("R1 zero means 65536 no done", got_done, 0);
        rd(4'd0, d); check("R1 zero wraps to FFFF", d, 16'hFFFF);
    endtask

    task automatic t_repeat();
        logic [CNT_W-1:0] d;
        int blks = 0;
        int dones = 0;
        do_reset();
        mode = 2'd1;
        wr(4'd0, 16'h0302);
        wr(4'd2, 16'h0001);
        req = '0; req[0] = 1'b1;
        for (int i = 1; i <= 11; i++) begin
            unit(got_blk, got_done);
            if (got_done) dones++;
            if (got_blk) blks++;
            if (i == 2) begin
                check("R3 first block after low byte count", got_blk, 1);
                rd(4'd0, d); check("R3 low byte reloaded", d, 16'h0303);
            end
            if (i == 1) check("R3 no block_end mid block", got_blk, 0);
        end
        check("R3 block count over 11 units", blks, 4);
        check("R4 repeat never done", dones, 0);
        rd(4'd2, d); check("R4 enable kept in repeat", d, 16'h0001);
    endtask

    task automatic t_low_zero();
        int first = 0;
        do_reset();
        mode = 2'd1;
        wr(4'd0, 16'h0100);
        wr(4'd2, 16'h0001);
        req = '0; req[0] = 1'b1;
        for (int i = 1; i <= 256; i++) begin
            unit(got_blk, got_done);
            if (got_blk && first == 0) first = i;
        end
        check("R3 low zero means 256", first, 256);
    endtask

    task automatic t_block();
        logic [CNT_W-1:0] d;
        int blks = 0;
        do_reset();
        mode = 2'd2;
        wr(4'd0, 16'h0202);
        wr(4'd1, 16'd2);
        wr(4'd2, 16'h0002);
        req = '0; req[1] = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            unit(got_blk, got_done);
            if (got_blk) blks++;
            if (i == 2) begin
                rd(4'd1, d); check("R5 B decremented per block", d, 1);
                check("R5 no done after first block", got_done, 0);
            end
            if (i == 4) check("R5 done on last block", got_done, 1);
        end
        check("R3 block_end per block", blks, 2);
        rd(4'd1, d); check("R5 B reaches zero", d, 0);
        rd(4'd2, d); check("R2 block done clears enable", d, 0);
    endtask

    task automatic t_write_wins();
        logic [CNT_W-1:0] d;
        do_reset();
        mode = 2'd0;
        wr(4'd0, 16'd1);
        wr(4'd2, 16'h0001);
        req = '0; req[0] = 1'b1;
        while (!grant_valid) @(negedge clk);
        unit_done = 1; wr_en = 1; wr_addr = 4'd0; wr_data = 16'h0010;
        @(negedge clk);
        unit_done = 0; wr_en = 0;
        check("R9 no done on colliding strobe", xfer_done, 0);
        rd(4'd0, d); check("R9 write value loaded", d, 16'h0010);
        rd(4'd2, d); check("R9 enable untouched", d, 16'h0001);
    endtask

    task automatic t_idle_mode();
        logic [CNT_W-1:0] d;
        do_reset();
        mode = 2'd3;
        wr(4'd0, 16'h0101);
        wr(4'd2, 16'h0001);
        req = '0; req[0] = 1'b1;
        unit(got_blk, got_done);
        check("R10 idle mode no pulse", {got_blk, got_done}, 0);
        rd(4'd0, d); check("R10 idle mode no count", d, 16'h0101);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_enable_map();
                t_ignore_disabled();
                t_priority_lowest();
                t_priority_hold();
                t_normal();
                t_normal_zero();
                t_repeat();
                t_low_zero();
                t_block();
                t_write_wins();
                t_idle_mode();
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule